// File: doc/BRIEF.md
# ADC Continuous Conversion Controller

This block sequences a successive-approximation converter core in software-started, free-running mode. Software drives three register-write strobes: an enable bit, a run bit and a channel field. The controller moves between three states: stopped, standby and converting. While converting it pulses a start to the core for the selected channel. When the core reports completion, the controller latches the core's result and raises a one-cycle interrupt. It then starts the next conversion in the same cycle, with no software action.

A run-bit rewrite or a channel write in the middle of a conversion throws that conversion away and starts a fresh one at once. A cleared run bit aborts the conversion and returns to standby. A cleared enable bit forces the block back to stopped. The hardware trigger input has no effect in this mode. The settling wait after enabling is left to software.

Top module: `adc_cont_ctrl`

## Requirements
- R1: After reset, state_o is 2'b00, result_o is 0, and eoc_irq_o, core_start_o and core_abort_o are all 0.
- R2: state_o encodes 2'b00 stopped, 2'b01 standby and 2'b10 converting, and never shows 2'b11. Writing enable=1 while stopped moves to standby on the next cycle without a start pulse.
- R3: Writing run=1 in standby raises core_start_o in the same cycle, with core_chan_o equal to the channel register, and state_o reads 2'b10 on the next cycle.
- R4: A core_done_i accepted while converting loads result_o and raises eoc_irq_o for one cycle on the next cycle. core_start_o is raised in the done cycle itself, so with a core latency of N the next interrupt follows N cycles later.
- R5: Writing run=1 while converting raises core_abort_o and core_start_o in that same cycle, and the block stays converting. The next interrupt comes N+1 cycles after the write.
- R6: A channel write while converting raises core_abort_o and core_start_o in that same cycle, and core_chan_o already shows the new channel. A channel write in standby only updates the register and produces no start.
- R7: Writing run=0 while converting raises core_abort_o with no start, and the block returns to standby on the next cycle. No interrupt and no result update follow.
- R8: A core_done_i in the same cycle as an abort is discarded: no interrupt on the next cycle and result_o unchanged.
- R9: Writing enable=0 returns the block to stopped. From converting, this also aborts the conversion. While the enable bit is 0, run=1 writes are ignored and are not remembered once enable is set again.
- R10: hw_trig_i has no effect in any state. It neither starts nor restarts a conversion.
- R11: result_o changes only on the cycle when eoc_irq_o is high. It holds through aborts and state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_wdata_i | input | 1 | Enable bit write value |
| start_wr_i | input | 1 | Write strobe for the run bit |
| start_wdata_i | input | 1 | Run bit write value |
| chan_wr_i | input | 1 | Write strobe for the channel field |
| chan_wdata_i | input | CH_W | Channel write value |
| hw_trig_i | input | 1 | Hardware trigger (no effect in this mode) |
| core_start_o | output | 1 | Start pulse to the converter core |
| core_abort_o | output | 1 | Abort pulse to the converter core |
| core_chan_o | output | CH_W | Channel for the conversion being started |
| core_done_i | input | 1 | Core completion strobe |
| core_result_i | input | RES_W | Core conversion result |
| result_o | output | RES_W | Result register |
| eoc_irq_o | output | 1 | End-of-conversion interrupt pulse |
| state_o | output | 2 | Current state: 00 stopped, 01 standby, 10 converting |

## Verification
The core's completion strobe and a software abort can land in the same cycle. The abort may be a run rewrite, a channel write or a run clear. The bench uses a core model with a fixed latency. It slides the abort write across every cycle offset of a conversion, up to and including the cycle of the done strobe. A collision passes only if no interrupt follows it and the result register keeps its old value. After a collision caused by a restart, the next interrupt must arrive exactly N+1 cycles after the write.

// File: rtl/adc_cont_pkg.sv
package adc_cont_pkg;
  typedef enum logic [1:0] {
    ST_STOP = 2'b00,
    ST_IDLE = 2'b01,
    ST_CONV = 2'b10
  } adc_state_e;

  // trigger path is tied off in software-started continuous mode
  localparam bit HW_TRIG_STARTS = 1'b0;
endpackage

// File: rtl/adc_cont_regs.sv
module adc_cont_regs #(
  parameter int CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_wr_i,
  input  logic            en_wdata_i,
  input  logic            start_wr_i,
  input  logic            start_wdata_i,
  input  logic            chan_wr_i,
  input  logic [CH_W-1:0] chan_wdata_i,
  output logic            en_nxt_o,
  output logic            run_nxt_o,
  output logic            run_set_o,
  output logic            chan_upd_o,
  output logic [CH_W-1:0] chan_eff_o
);
  logic            en_q, run_q;
  logic [CH_W-1:0] chan_q;

  always_comb begin
    en_nxt_o   = en_wr_i ? en_wdata_i : en_q;
    run_set_o  = start_wr_i & start_wdata_i & en_nxt_o;
    // run bit cannot survive a disabled cycle
    if (!en_nxt_o)       run_nxt_o = 1'b0;
    else if (start_wr_i) run_nxt_o = start_wdata_i;
    else                 run_nxt_o = run_q;
    chan_upd_o = chan_wr_i;
    chan_eff_o = chan_wr_i ? chan_wdata_i : chan_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      chan_q <= '0;
    end else begin
      en_q   <= en_nxt_o;
      run_q  <= run_nxt_o;
      chan_q <= chan_eff_o;
    end
  end
endmodule

// File: rtl/adc_cont_fsm.sv
module adc_cont_fsm
  import adc_cont_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_nxt_i,
  input  logic       run_nxt_i,
  input  logic       run_set_i,
  input  logic       chan_upd_i,
  input  logic       hw_trig_i,
  input  logic       core_done_i,
  output logic       core_start_o,
  output logic       core_abort_o,
  output logic       accept_o,
  output logic [1:0] state_o
);
  adc_state_e state_q, state_d;
  logic       conv, begin_go, restart_go, trig_go;

  always_comb begin
    if (!en_nxt_i)      state_d = ST_STOP;
    else if (run_nxt_i) state_d = ST_CONV;
    else                state_d = ST_IDLE;

    conv         = (state_q == ST_CONV);
    core_abort_o = conv & (~run_nxt_i | run_set_i | chan_upd_i);
    accept_o     = conv & core_done_i & ~core_abort_o;
    begin_go     = ~conv & run_nxt_i;
    restart_go   = conv & run_nxt_i & (run_set_i | chan_upd_i);
    trig_go      = HW_TRIG_STARTS & hw_trig_i & (state_q == ST_IDLE) & en_nxt_i;
    core_start_o = begin_go | restart_go | accept_o | trig_go;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_STOP;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/adc_cont_result.sv
module adc_cont_result #(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [RES_W-1:0] core_result_i,
  output logic [RES_W-1:0] result_o,
  output logic             eoc_irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      eoc_irq_o <= 1'b0;
    end else begin
      eoc_irq_o <= accept_i;
      if (accept_i) result_o <= core_result_i;
    end
  end
endmodule

// File: rtl/adc_cont_ctrl.sv
module adc_cont_ctrl #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_wr_i,
  input  logic             en_wdata_i,
  input  logic             start_wr_i,
  input  logic             start_wdata_i,
  input  logic             chan_wr_i,
  input  logic [CH_W-1:0]  chan_wdata_i,
  input  logic             hw_trig_i,
  output logic             core_start_o,
  output logic             core_abort_o,
  output logic [CH_W-1:0]  core_chan_o,
  input  logic             core_done_i,
  input  logic [RES_W-1:0] core_result_i,
  output logic [RES_W-1:0] result_o,
  output logic             eoc_irq_o,
  output logic [1:0]       state_o
);
  logic en_nxt, run_nxt, run_set, chan_upd, accept;

  adc_cont_regs #(.CH_W(CH_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_wr_i      (en_wr_i),
    .en_wdata_i   (en_wdata_i),
    .start_wr_i   (start_wr_i),
    .start_wdata_i(start_wdata_i),
    .chan_wr_i    (chan_wr_i),
    .chan_wdata_i (chan_wdata_i),
    .en_nxt_o     (en_nxt),
    .run_nxt_o    (run_nxt),
    .run_set_o    (run_set),
    .chan_upd_o   (chan_upd),
    .chan_eff_o   (core_chan_o)
  );

  adc_cont_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_nxt_i    (en_nxt),
    .run_nxt_i   (run_nxt),
    .run_set_i   (run_set),
    .chan_upd_i  (chan_upd),
    .hw_trig_i   (hw_trig_i),
    .core_done_i (core_done_i),
    .core_start_o(core_start_o),
    .core_abort_o(core_abort_o),
    .accept_o    (accept),
    .state_o     (state_o)
  );

  adc_cont_result #(.RES_W(RES_W)) u_res (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .core_result_i(core_result_i),
    .result_o     (result_o),
    .eoc_irq_o    (eoc_irq_o)
  );
endmodule

// File: rtl/adc_cont_ctrl_chk.sv
module adc_cont_ctrl_chk #(
  parameter int CH_W  = 3,
  parameter int RES_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_wr_i,
  input logic             en_wdata_i,
  input logic             start_wr_i,
  input logic             core_start_o,
  input logic             core_abort_o,
  input logic             core_done_i,
  input logic [RES_W-1:0] result_o,
  input logic             eoc_irq_o,
  input logic [1:0]       state_o
);
  assert_state_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'b11);

  assert_abort_only_conv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_abort_o |-> state_o == 2'b10);

  assert_stop_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b00 && !(en_wr_i && en_wdata_i)) |=> state_o == 2'b00);

  assert_irq_after_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_irq_o |-> ($past(core_done_i) && $past(state_o) == 2'b10 && !$past(core_abort_o)));

  assert_result_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_irq_o |-> $stable(result_o));

  assert_restart_stays_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_abort_o && core_start_o) |=> state_o == 2'b10);

  assert_auto_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b10 && core_done_i && !core_abort_o) |-> core_start_o);

  assert_idle_no_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b01 && !start_wr_i && !en_wr_i) |-> !core_start_o);

  assert_idle_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b01 && !start_wr_i && !en_wr_i) |=> state_o == 2'b01);
endmodule

bind adc_cont_ctrl adc_cont_ctrl_chk #(.CH_W(CH_W), .RES_W(RES_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_wr_i     (en_wr_i),
  .en_wdata_i  (en_wdata_i),
  .start_wr_i  (start_wr_i),
  .core_start_o(core_start_o),
  .core_abort_o(core_abort_o),
  .core_done_i (core_done_i),
  .result_o    (result_o),
  .eoc_irq_o   (eoc_irq_o),
  .state_o     (state_o)
);

// File: tb/adc_cont_ctrl_test.sv
module adc_cont_ctrl_test;
  localparam int CLK_P  = 10;
  localparam int NUM_CH = 8;
  localparam int RES_W  = 10;
  localparam int CH_W   = 3;
  localparam int LAT    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_wr = 1'b0, en_wdata = 1'b0, start_wr = 1'b0, start_wdata = 1'b0;
  logic chan_wr = 1'b0, hw_trig = 1'b0;
  logic [CH_W-1:0]  chan_wdata = '0;
  logic             core_start, core_abort, core_done, eoc_irq;
  logic [CH_W-1:0]  core_chan, cap_ch;
  logic [RES_W-1:0] core_result, result;
  logic [1:0]       state;
  int               cnt;
  int total = 0, bad = 0, last_res = 0, lat = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  adc_cont_ctrl #(.NUM_CH(NUM_CH), .RES_W(RES_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .start_wr_i(start_wr), .start_wdata_i(start_wdata),
    .chan_wr_i(chan_wr), .chan_wdata_i(chan_wdata),
    .hw_trig_i(hw_trig),
    .core_start_o(core_start), .core_abort_o(core_abort), .core_chan_o(core_chan),
    .core_done_i(core_done), .core_result_i(core_result),
    .result_o(result), .eoc_irq_o(eoc_irq), .state_o(state)
  );

  // fixed-latency core model
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= 0; cap_ch <= '0;
    end else if (core_start) begin
      cnt <= LAT; cap_ch <= core_chan;
    end else if (core_abort) cnt <= 0;
    else if (cnt > 0)        cnt <= cnt - 1;
  end
  assign core_done   = (cnt == 1);
  assign core_result = RES_W'(int'(cap_ch) * 37 + 5);

  function automatic int exp_res(int ch);
    return ch * 37 + 5;
  endfunction

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic next();
    @(negedge clk);
    en_wr = 1'b0; start_wr = 1'b0; chan_wr = 1'b0; hw_trig = 1'b0;
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    for (int i = 0; i < 3*LAT; i++) begin
      next(); n++;
      if (eoc_irq) break;
    end
  endtask

  task automatic run_write(bit v);
    next(); start_wr = 1'b1; start_wdata = v; settle();
  endtask

  task automatic stop_now();
    start_wr = 1'b1; start_wdata = 1'b0; settle();
    chk("R7 abort on clear", int'(core_abort), 1);
    next();
    chk("R7 standby after clear", int'(state), 1);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R1 state", int'(state), 0);
    chk("R1 result", int'(result), 0);
    chk("R1 irq", int'(eoc_irq), 0);
    chk("R1 start", int'(core_start), 0);
    chk("R1 abort", int'(core_abort), 0);
    @(negedge clk); rst_n = 1'b1;

    // run write while disabled
    run_write(1'b1);
    chk("R9 start ignored", int'(core_start), 0);
    next();
    chk("R9 stays stopped", int'(state), 0);

    next(); en_wr = 1'b1; en_wdata = 1'b1; settle();
    chk("R2 no start on enable", int'(core_start), 0);
    next();
    chk("R2 standby", int'(state), 1);

    for (int i = 0; i < 3; i++) begin
      next(); hw_trig = 1'b1; settle();
      chk("R10 trig idle", int'(core_start), 0);
    end
    next();
    chk("R10 idle held", int'(state), 1);

    // sweep all channels
    for (int ch = 0; ch < NUM_CH; ch++) begin
      next(); chan_wr = 1'b1; chan_wdata = CH_W'(ch); settle();
      chk("R6 idle chan no start", int'(core_start | core_abort), 0);
      run_write(1'b1);
      chk("R3 start", int'(core_start), 1);
      chk("R3 chan", int'(core_chan), ch);
      next();
      chk("R3 converting", int'(state), 2);
      wait_irq(lat);
      chk("R4 latency", lat, LAT);
      chk("R4 result", int'(result), exp_res(ch));
      chk("R4 auto restart", int'(state), 2);
      last_res = exp_res(ch);
      stop_now();
      chk("R7 no irq", int'(eoc_irq), 0);
    end

    // run rewrite at each offset, incl. the done cycle
    next(); chan_wr = 1'b1; chan_wdata = 3'd2; settle();
    for (int j = 1; j <= LAT; j++) begin
      run_write(1'b1);
      repeat (j) next();
      start_wr = 1'b1; start_wdata = 1'b1; settle();
      chk("R5 abort", int'(core_abort), 1);
      chk("R5 start", int'(core_start), 1);
      wait_irq(lat);
      chk("R5 R8 restart latency", lat, LAT + 1);
      chk("R5 result", int'(result), exp_res(2));
      last_res = exp_res(2);
      stop_now();
    end

    // channel write at each offset
    for (int j = 1; j <= LAT; j++) begin
      next(); chan_wr = 1'b1; chan_wdata = 3'd1; settle();
      run_write(1'b1);
      repeat (j) next();
      chan_wr = 1'b1; chan_wdata = 3'd6; settle();
      chk("R6 abort", int'(core_abort), 1);
      chk("R6 start", int'(core_start), 1);
      chk("R6 new chan", int'(core_chan), 6);
      wait_irq(lat);
      chk("R6 latency", lat, LAT + 1);
      chk("R6 result", int'(result), exp_res(6));
      last_res = exp_res(6);
      stop_now();
    end

    // clear in the done cycle
    next(); chan_wr = 1'b1; chan_wdata = 3'd3; settle();
    run_write(1'b1);
    repeat (LAT) next();
    chk("R8 done present", int'(core_done), 1);
    start_wr = 1'b1; start_wdata = 1'b0; settle();
    chk("R8 abort", int'(core_abort), 1);
    chk("R8 no start", int'(core_start), 0);
    next();
    chk("R8 no irq", int'(eoc_irq), 0);
    chk("R11 result held", int'(result), last_res);
    chk("R7 standby", int'(state), 1);

    // clear mid conversion
    run_write(1'b1);
    repeat (2) next();
    start_wr = 1'b1; start_wdata = 1'b0; settle();
    chk("R7 abort mid", int'(core_abort), 1);
    lat = 0;
    for (int i = 0; i < LAT + 2; i++) begin
      next();
      if (eoc_irq) lat++;
    end
    chk("R7 no irq after abort", lat, 0);
    chk("R11 result held", int'(result), last_res);

    // trigger held during conversion
    run_write(1'b1);
    for (int i = 1; i <= LAT; i++) begin
      next(); hw_trig = 1'b1; settle();
      chk("R10 trig conv", int'(core_start), (i == LAT) ? 1 : 0);
    end
    next();
    chk("R10 irq on time", int'(eoc_irq), 1);
    chk("R10 result", int'(result), exp_res(3));
    last_res = exp_res(3);
    stop_now();

    // enable clear from standby and from converting
    next(); en_wr = 1'b1; en_wdata = 1'b0; settle();
    next();
    chk("R9 stopped from standby", int'(state), 0);
    next(); en_wr = 1'b1; en_wdata = 1'b1; settle();
    run_write(1'b1);
    next(); next();
    en_wr = 1'b1; en_wdata = 1'b0; settle();
    chk("R9 abort on disable", int'(core_abort), 1);
    next();
    chk("R9 stopped from conv", int'(state), 0);
    run_write(1'b1);
    chk("R9 start ignored again", int'(core_start), 0);
    next(); en_wr = 1'b1; en_wdata = 1'b1; settle();
    chk("R9 run not remembered", int'(core_start), 0);
    next();
    chk("R9 standby only", int'(state), 1);
    chk("R11 result held", int'(result), last_res);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule